// File: doc/BRIEF.md
# Dual-Threshold Time-Over-Threshold Hit Recorder

This block is the digital back end for a bank of strip-detector channels. Each channel has two discriminator outputs. The low one sits near a quarter of a minimum-ionizing signal. The high one is set at a higher readout level. Both are sampled once per slow sample period, and a free-running event-time counter advances on the same period. For each pulse on the low discriminator, the block stamps the rising and the falling transition. The pulse amplitude can then be recovered from the width of the pulse.

A pulse is kept only if the high discriminator was seen asserted at a sample where the low one was also asserted. A kept pulse is written into a small per-channel queue as a {lead, trail} pair. The queues of all channels share one output lane by fixed time slots. The lane runs on the fast clock, and each channel owns one fast cycle out of every NUM_CH. The slow sample period is therefore NUM_CH fast cycles, and the block derives it from the single fast clock.

Top module: `tot_hit_recorder`

## Requirements
- R1: While `rst_n` is low, the outputs hold these values at every clock edge: `laneValid`=0, `laneData`=0, `overflow`=0 and `laneSlot`=NUM_CH-1.
- R2: Counting edges from reset release, the sample tick falls on edges NUM_CH, 2*NUM_CH and so on; tick m is edge m*NUM_CH. `laneSlot` advances 0,1,…,NUM_CH-1 and then returns to 0, one step per clock, with no gaps.
- R3: Suppose a level change of the low input is first seen by sample tick m. The transition is then stamped (m+1) mod 2^TIME_W.
- R4: A lane entry puts the leading-edge stamp in `laneData[2*TIME_W-1:TIME_W]` and the trailing-edge stamp in `laneData[TIME_W-1:0]`. Their difference modulo 2^TIME_W equals the number of samples for which the low input was high.
- R5: A pulse produces an entry only if the high input was sampled 1 on at least one tick where the low input was sampled 1 in that pulse. Otherwise the pulse leaves no entry.
- R6: A low pulse lasting a single sample is recorded like any other pulse, with stamps that differ by 1.
- R7: Stamps wrap modulo 2^TIME_W. A pulse that straddles the wrap yields a trail stamp smaller than its lead stamp.
- R8: A pulse whose low input is already high at the first sample tick after reset release is ignored, whatever the high input does. The next complete pulse on that channel is recorded.
- R9: Suppose channel c has an empty queue and its pulse's trailing edge is first seen at tick b. The entry then appears on the lane with `laneValid`=1 and `laneSlot`=c right after edge (b+2)*NUM_CH+c+1, and the entry is then removed. In any cycle with `laneValid`=0, `laneData` is 0.
- R10: A pair that completes while its channel queue holds DEPTH entries is dropped, and it sets that channel's `overflow` bit until reset. The drain rate is one entry per channel per period, and a new pair arrives at most once every two periods. So a queue never holds more than one entry and `overflow` stays 0.
- R11: Channels are independent. Pulses arriving on all channels at the same time are all recorded, each on its own slot only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast lane clock; one sample tick every NUM_CH cycles |
| rst_n | input | 1 | Synchronous active-low reset; also clears the overflow flags |
| compLow | input | NUM_CH | Low-threshold discriminator outputs, asynchronous |
| compHigh | input | NUM_CH | Readout-threshold discriminator outputs, asynchronous |
| laneValid | output | 1 | Lane carries an entry this cycle |
| laneSlot | output | $clog2(NUM_CH) | Channel that owns the current lane slot |
| laneData | output | 2*TIME_W | {lead stamp, trail stamp}, zero when not valid |
| overflow | output | NUM_CH | Sticky per-channel dropped-pair flags |

## Verification
The bench builds the block with its defaults: 8 channels, 12-bit stamps and a queue depth of 4. A 12-bit counter wraps after 4096 sample ticks, about 33k fast cycles, so the bench can jump across the wrap and check stamps on both sides of it. The eight channels receive pulse lengths of 1 to 4 samples and high-threshold windows of 1 or 3 samples. The high window is swept from before the low pulse to after it, which covers every overlap and non-overlap case for each slot position on the lane. A second reset with all inputs held high covers the start-up suppression.

// File: rtl/tot_pkg.sv
package tot_pkg;

  // Per-channel strobes from the control side to the datapath
  typedef struct packed {
    logic latchLead;   // leading edge seen on this sample tick
    logic commitPair;  // qualified trailing edge: push {lead, now}
  } chStrb_t;

endpackage

// File: rtl/tot_ctrl.sv
module tot_ctrl
  import tot_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   compLow,
  input  logic [NUM_CH-1:0]   compHigh,
  output logic                tick,
  output logic [SLOT_W-1:0]   slot,
  output chStrb_t [NUM_CH-1:0] chStrb
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

  // Slot counter: one lane slot per fast cycle, a sample tick per round
  always_ff @(posedge clk) begin
    if (!rst_n)                 slot <= '0;
    else if (slot == LAST_SLOT) slot <= '0;
    else                        slot <= slot + 1'b1;
  end

  assign tick = (slot == LAST_SLOT);

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic lowS1, lowS2, lowS3;
    logic hiS1, hiS2;
    logic pending, hitSeen;
    logic riseDet, fallDet;

    // lowS2 and hiS2 are aligned samples; lowS3 is the previous low sample
    assign riseDet = lowS2 & ~lowS3;
    assign fallDet = ~lowS2 & lowS3;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        // low history resets high: a pulse present at release never rises
        lowS1   <= 1'b1;
        lowS2   <= 1'b1;
        lowS3   <= 1'b1;
        hiS1    <= 1'b0;
        hiS2    <= 1'b0;
        pending <= 1'b0;
        hitSeen <= 1'b0;
      end else if (tick) begin
        lowS1 <= compLow[g];
        lowS2 <= lowS1;
        lowS3 <= lowS2;
        hiS1  <= compHigh[g];
        hiS2  <= hiS1;
        if (riseDet) begin
          pending <= 1'b1;
          hitSeen <= hiS2;
        end else if (fallDet) begin
          pending <= 1'b0;
          hitSeen <= 1'b0;
        end else if (pending && lowS2) begin
          hitSeen <= hitSeen | hiS2;
        end
      end
    end

    assign chStrb[g].latchLead  = tick & riseDet;
    assign chStrb[g].commitPair = tick & fallDet & pending & hitSeen;
  end

endmodule

// File: rtl/tot_datapath.sv
module tot_datapath
  import tot_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 12,
  parameter int DEPTH  = 4,
  localparam int SLOT_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ENTRY_W = 2 * TIME_W,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [SLOT_W-1:0]       slot,
  input  chStrb_t [NUM_CH-1:0]    chStrb,
  output logic                    laneValid,
  output logic [SLOT_W-1:0]       laneSlot,
  output logic [ENTRY_W-1:0]      laneData,
  output logic [NUM_CH-1:0]       overflow,
  output logic [NUM_CH*CNT_W-1:0] fifoLevel
);

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // Free-running event time, one step per sample tick
  logic [TIME_W-1:0] evTime;
  always_ff @(posedge clk) begin
    if (!rst_n)    evTime <= '0;
    else if (tick) evTime <= evTime + 1'b1;
  end

  logic [ENTRY_W-1:0] headArr [NUM_CH];
  logic [NUM_CH-1:0]  notEmpty;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [TIME_W-1:0]  leadTime;
    logic [ENTRY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]   wrPtr, rdPtr;
    logic [CNT_W-1:0]   level;
    logic               isFull, doPush, doPop, ovfFlag;

    assign isFull = (level == CNT_W'(DEPTH));
    assign doPush = chStrb[g].commitPair & ~isFull;
    assign doPop  = (slot == SLOT_W'(g)) & (level != '0);

    always_ff @(posedge clk) begin
      if (!rst_n)                    leadTime <= '0;
      else if (chStrb[g].latchLead)  leadTime <= evTime;
    end

    always_ff @(posedge clk) begin
      if (doPush) mem[wrPtr] <= {leadTime, evTime};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wrPtr   <= '0;
        rdPtr   <= '0;
        level   <= '0;
        ovfFlag <= 1'b0;
      end else begin
        if (doPush) wrPtr <= nextPtr(wrPtr);
        if (doPop)  rdPtr <= nextPtr(rdPtr);
        level <= level + CNT_W'(doPush) - CNT_W'(doPop);
        if (chStrb[g].commitPair && isFull) ovfFlag <= 1'b1;
      end
    end

    assign headArr[g]                   = mem[rdPtr];
    assign notEmpty[g]                  = (level != '0);
    assign overflow[g]                  = ovfFlag;
    assign fifoLevel[g*CNT_W +: CNT_W]  = level;
  end

  // Lane: registered, one slot per cycle, pops the owner's head entry
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      laneValid <= 1'b0;
      laneSlot  <= SLOT_W'(NUM_CH - 1);
      laneData  <= '0;
    end else begin
      laneValid <= notEmpty[slot];
      laneSlot  <= slot;
      laneData  <= notEmpty[slot] ? headArr[slot] : '0;
    end
  end

endmodule

// File: rtl/tot_hit_recorder.sv
module tot_hit_recorder
  import tot_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 12,
  parameter int DEPTH  = 4,
  localparam int SLOT_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ENTRY_W = 2 * TIME_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CH-1:0]  compLow,
  input  logic [NUM_CH-1:0]  compHigh,
  output logic               laneValid,
  output logic [SLOT_W-1:0]  laneSlot,
  output logic [ENTRY_W-1:0] laneData,
  output logic [NUM_CH-1:0]  overflow
);

  logic                     tick;
  logic [SLOT_W-1:0]        slot;
  chStrb_t [NUM_CH-1:0]     chStrb;
  logic [NUM_CH*CNT_W-1:0]  fifoLevel;

  tot_ctrl #(.NUM_CH(NUM_CH)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .compLow  (compLow),
    .compHigh (compHigh),
    .tick     (tick),
    .slot     (slot),
    .chStrb   (chStrb)
  );

  tot_datapath #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .DEPTH(DEPTH)) uData (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .slot      (slot),
    .chStrb    (chStrb),
    .laneValid (laneValid),
    .laneSlot  (laneSlot),
    .laneData  (laneData),
    .overflow  (overflow),
    .fifoLevel (fifoLevel)
  );

endmodule

// File: rtl/tot_hit_checker.sv
module tot_hit_checker #(
  parameter int NUM_CH = 8,
  parameter int TIME_W = 12,
  parameter int DEPTH  = 4,
  localparam int SLOT_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ENTRY_W = 2 * TIME_W,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    laneValid,
  input logic [SLOT_W-1:0]       laneSlot,
  input logic [ENTRY_W-1:0]      laneData,
  input logic [NUM_CH-1:0]       overflow,
  input logic [NUM_CH*CNT_W-1:0] fifoLevel
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);

  assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (laneSlot == (($past(laneSlot) == LAST_SLOT) ? SLOT_W'(0)
                                                                  : SLOT_W'($past(laneSlot) + 1'b1))))
    else $error("lane slot skipped");

  assert_tot_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    laneValid |-> (laneData[ENTRY_W-1:TIME_W] != laneData[TIME_W-1:0]))
    else $error("entry with zero width");

  assert_idle_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !laneValid |-> (laneData == '0))
    else $error("idle lane carries data");

  assert_sticky_ovf_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (($past(overflow) & ~overflow) == '0))
    else $error("overflow flag cleared without reset");

  for (genvar g = 0; g < NUM_CH; g++) begin : gLvl
    assert_fifo_shallow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifoLevel[g*CNT_W +: CNT_W] <= CNT_W'(1))
      else $error("queue deeper than drain rate allows");
  end

endmodule

bind tot_hit_recorder tot_hit_checker #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .DEPTH(DEPTH)) uChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .laneValid (laneValid),
  .laneSlot  (laneSlot),
  .laneData  (laneData),
  .overflow  (overflow),
  .fifoLevel (fifoLevel)
);

// File: tb/tot_hit_recorder_test.sv
module tot_hit_recorder_test;
  localparam int NCH = 8;
  localparam int TW  = 12;
  localparam int MAXE = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n = 1'b0;
  logic [NCH-1:0]  compLow = '0;
  logic [NCH-1:0]  compHigh = '0;
  logic            laneValid;
  logic [2:0]      laneSlot;
  logic [2*TW-1:0] laneData;
  logic [NCH-1:0]  overflow;

  tot_hit_recorder uut (
    .clk(clk), .rst_n(rst_n), .compLow(compLow), .compHigh(compHigh),
    .laneValid(laneValid), .laneSlot(laneSlot), .laneData(laneData), .overflow(overflow)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  logic [2*TW-1:0] expData [NCH][MAXE];
  int expCyc [NCH][MAXE];
  int expN [NCH];
  int gotN [NCH];

  // edges since reset release; tick m is edge 8*m (R2)
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic addExpect(input int c, input int a0, input int b0);
    if (expN[c] < MAXE) begin
      expData[c][expN[c]] = {TW'(a0 + 1), TW'(b0 + 1)};
      expCyc[c][expN[c]]  = 8 * (b0 + 2) + c + 1;
      expN[c]++;
    end
  endtask

  task automatic clearExpect();
    for (int c = 0; c < NCH; c++) begin
      expN[c] = 0;
      gotN[c] = 0;
    end
  endtask

  // place inputs so that tick m is the first to sample them
  task automatic gotoTick(input int m);
    while (cyc != 8 * (m - 1)) @(negedge clk);
  endtask

  task automatic checkReset();
    check(laneValid == 1'b0, "R1", "laneValid in reset", laneValid, 0);
    check(laneData == '0, "R1", "laneData in reset", laneData, 0);
    check(overflow == '0, "R1", "overflow in reset", overflow, 0);
    check(laneSlot == 3'd7, "R1", "laneSlot in reset", laneSlot, 7);
  endtask

  // one round: a low pulse of length 1..4 on every channel, high window swept
  task automatic runRound(input int r, input int base);
    int a [NCH];
    int b [NCH];
    int h [NCH];
    int hl [NCH];
    for (int c = 0; c < NCH; c++) begin
      int len;
      len   = 1 + ((r + c) % 4);
      a[c]  = base + 3;
      b[c]  = a[c] + len;
      hl[c] = 1 + 2 * (r % 2);
      h[c]  = a[c] + ((r * 3 + c * 5) % (len + 4)) - 2;
      // R5: kept only if some high sample overlaps the low pulse
      if (h[c] < b[c] && h[c] + hl[c] > a[c]) addExpect(c, a[c], b[c]);
    end
    for (int m = base; m < base + 12; m++) begin
      gotoTick(m);
      for (int c = 0; c < NCH; c++) begin
        compLow[c]  = (m >= a[c] && m < b[c]);
        compHigh[c] = (m >= h[c] && m < h[c] + hl[c]);
      end
    end
  endtask

  task automatic checkCounts(input string req);
    for (int c = 0; c < NCH; c++)
      check(gotN[c] == expN[c], req, $sformatf("entry count ch%0d", c), gotN[c], expN[c]);
    check(overflow == '0, "R10", "overflow stays clear", overflow, 0);
  endtask

  // lane monitor, away from the active edge
  int prevSlot = -1;
  always @(negedge clk) begin
    if (!rst_n) begin
      prevSlot = -1;
    end else begin
      if (prevSlot >= 0)
        check(int'(laneSlot) == (prevSlot + 1) % NCH, "R2", "slot order",
              laneSlot, (prevSlot + 1) % NCH);
      prevSlot = int'(laneSlot);
      if (laneValid) begin
        int ch;
        int k;
        ch = int'(laneSlot);
        k  = gotN[ch];
        if (k < expN[ch]) begin
          logic [TW-1:0] eLead, eTrail;
          string tag;
          eLead  = expData[ch][k][2*TW-1:TW];
          eTrail = expData[ch][k][TW-1:0];
          if (eTrail < eLead)             tag = "R7";
          else if (eTrail - eLead == 1)   tag = "R6";
          else                            tag = "R3 R4";
          check(laneData == expData[ch][k], tag, $sformatf("entry ch%0d", ch),
                laneData, expData[ch][k]);
          check(cyc == expCyc[ch][k], "R9", $sformatf("delivery cycle ch%0d", ch),
                cyc, expCyc[ch][k]);
        end else begin
          check(1'b0, "R5 R11", $sformatf("unexpected entry ch%0d", ch), laneData, 0);
        end
        gotN[ch]++;
      end else begin
        check(laneData == '0, "R9", "idle lane data", laneData, 0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearExpect();
    repeat (3) @(negedge clk);
    checkReset();                       // R1
    rst_n = 1'b1;

    // sweep pulse lengths and high-window placements on all channels (R3-R6, R9, R11)
    for (int r = 0; r < 32; r++) runRound(r, 2 + 12 * r);
    gotoTick(2 + 12 * 32 + 4);
    checkCounts("R5 R11");

    // cross the 12-bit wrap (R7)
    clearExpect();
    runRound(32, 4090);
    runRound(33, 4102);
    gotoTick(4120);
    checkCounts("R7 R5");

    // pulse present at reset release is ignored (R8)
    @(negedge clk);
    compLow  = '1;
    compHigh = '1;
    rst_n    = 1'b0;
    clearExpect();
    repeat (3) @(negedge clk);
    checkReset();                       // R1
    rst_n = 1'b1;
    for (int c = 0; c < NCH; c++) addExpect(c, 6, 8);
    gotoTick(4);
    compLow  = '0;
    compHigh = '0;
    gotoTick(6);
    compLow  = '1;
    compHigh = '1;
    gotoTick(8);
    compLow  = '0;
    compHigh = '0;
    gotoTick(14);
    checkCounts("R8");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule